// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds several copies of one register, all reached through a single bus address. The copies are organised as a number of groups with a fixed number of copies in each group. A second bus address holds a steering selector with three fields: a group number, a copy number within that group, and a broadcast flag. The selector decides which copy, or which copies, a data access touches.

A write to the shared address with the broadcast flag set loads every copy that is currently enabled. With the flag clear, the write loads only the copy that the selector points at. A read of the shared address always returns one copy, the one the selector points at, whatever the broadcast flag says. Each copy has an enable input that models fusing or power gating. An access that lands on a disabled copy, or on a group or copy number that does not exist, is terminated: a read returns zero and a write is dropped. The bus completes the access normally and gives no error.

Every access completes in one cycle. The bus answer, carrying ready and read data, is registered and appears on the cycle after the request.

Top module: `steer_bank`

## Requirements
- R1: After reset the selector reads 32'h8000_0000 (broadcast flag set, group 0, copy 0) and every copy holds zero.
- R2: The selector sits at address 8'h00. It holds the copy number in bits [1:0], the group number in bits [3:2] and the broadcast flag in bit 31. It reads back what was last written to those fields, and all its other bits read as zero.
- R3: A write to the shared address 8'h04 with the broadcast flag set loads the write data into every enabled copy.
- R4: A broadcast write leaves every disabled copy unchanged.
- R5: A write with the broadcast flag clear loads only the copy numbered group*COPIES_PER_GROUP+copy. All other copies keep their values.
- R6: A write with the broadcast flag clear is dropped when it is steered to a disabled copy.
- R7: A read of the shared address returns the steered copy, with the same result whether the broadcast flag is set or clear.
- R8: A read steered to a disabled copy returns zero.
- R9: A request with bus_valid high in one cycle gives bus_ready high in the next cycle, terminated accesses included. bus_ready is low after any cycle without a request.
- R10: A group number of GROUPS or more, or a copy number of COPIES_PER_GROUP or more, counts as a terminated target: reads return zero and writes with the broadcast flag clear change no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completed (one cycle after the request) |
| copy_en | input | GROUPS*COPIES_PER_GROUP | Per-copy enable; 0 = fused off or power-gated |

## Verification
The assertions check the behaviour that must hold on every cycle. They check the one-cycle ready answer. They check that a write with the broadcast flag clear loads at most one copy. They check that a disabled copy never changes, and that a terminated read returns zero. Other properties depend on values stored earlier, and only the bench's scenarios can show them: the copy the steering picks, the values a broadcast or a dropped write leaves in each copy, and read results that match under either broadcast setting. To see these, the bench steers to each copy in turn and reads back its stored value.

// File: rtl/steer_pkg.sv
package steer_pkg;

  // width of an ID field able to hold 0..n-1, never below one bit
  function automatic int field_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // linear position of a copy inside the bank
  function automatic int flat_idx(input int grp, input int cpy, input int per_grp);
    return grp * per_grp + cpy;
  endfunction

endpackage

// File: rtl/steer_sel_reg.sv
module steer_sel_reg #(
  parameter int DATA_W = 32,
  parameter int GW     = 2,
  parameter int IW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GW-1:0]     wr_gid,
  input  logic [IW-1:0]     wr_cid,
  input  logic              wr_bcast,
  output logic [GW-1:0]     gid,
  output logic [IW-1:0]     cid,
  output logic              bcast,
  output logic [DATA_W-1:0] rd_word
);
  localparam int PAD_W = DATA_W - 1 - GW - IW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gid   <= '0;
      cid   <= '0;
      bcast <= 1'b1;
    end else if (wr_en) begin
      gid   <= wr_gid;
      cid   <= wr_cid;
      bcast <= wr_bcast;
    end
  end

  assign rd_word = {bcast, {PAD_W{1'b0}}, gid, cid};

endmodule

// File: rtl/steer_target.sv
module steer_target #(
  parameter int GROUPS          = 3,
  parameter int COPIES_PER_GROUP = 3,
  parameter int GW              = 2,
  parameter int IW              = 2,
  localparam int N              = GROUPS * COPIES_PER_GROUP
) (
  input  logic [GW-1:0] gid,
  input  logic [IW-1:0] cid,
  input  logic          bcast,
  input  logic [N-1:0]  copy_en,
  output logic [N-1:0]  uni_hit,
  output logic [N-1:0]  wr_mask,
  output logic          live
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar c = 0; c < COPIES_PER_GROUP; c++) begin : g_cpy
      localparam int K = steer_pkg::flat_idx(g, c, COPIES_PER_GROUP);
      assign uni_hit[K] = (gid == GW'(g)) && (cid == IW'(c));
    end
  end

  assign live    = |(uni_hit & copy_en);
  assign wr_mask = bcast ? copy_en : (uni_hit & copy_en);

endmodule

// File: rtl/steer_cell.sv
module steer_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (we) q <= wdata;
  end

  // R4 / R6: a gated copy never changes, whatever the steering decided
  a_r4_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/steer_bank.sv
module steer_bank #(
  parameter int DATA_W           = 32,
  parameter int ADDR_W           = 8,
  parameter int GROUPS           = 3,
  parameter int COPIES_PER_GROUP = 3,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h04,
  localparam int N  = GROUPS * COPIES_PER_GROUP,
  localparam int GW = steer_pkg::field_w(GROUPS),
  localparam int IW = steer_pkg::field_w(COPIES_PER_GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [N-1:0]      copy_en
);
  // named access events
  logic sel_wr, sel_rd, dat_wr, dat_rd;
  assign sel_wr = bus_valid &&  bus_we && (bus_addr == SEL_ADDR);
  assign sel_rd = bus_valid && !bus_we && (bus_addr == SEL_ADDR);
  assign dat_wr = bus_valid &&  bus_we && (bus_addr == DATA_ADDR);
  assign dat_rd = bus_valid && !bus_we && (bus_addr == DATA_ADDR);

  logic [GW-1:0]     gid;
  logic [IW-1:0]     cid;
  logic              bcast;
  logic [DATA_W-1:0] sel_word;

  steer_sel_reg #(.DATA_W(DATA_W), .GW(GW), .IW(IW)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_wr),
    .wr_gid(bus_wdata[IW+GW-1:IW]), .wr_cid(bus_wdata[IW-1:0]),
    .wr_bcast(bus_wdata[DATA_W-1]),
    .gid(gid), .cid(cid), .bcast(bcast), .rd_word(sel_word)
  );

  logic [N-1:0] uni_hit, wr_mask;
  logic         live;

  steer_target #(.GROUPS(GROUPS), .COPIES_PER_GROUP(COPIES_PER_GROUP),
                 .GW(GW), .IW(IW)) u_tgt (
    .gid(gid), .cid(cid), .bcast(bcast), .copy_en(copy_en),
    .uni_hit(uni_hit), .wr_mask(wr_mask), .live(live)
  );

  logic [DATA_W-1:0] cell_q [N];

  for (genvar k = 0; k < N; k++) begin : g_cell
    steer_cell #(.DATA_W(DATA_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .en(copy_en[k]),
      .we(dat_wr && wr_mask[k]), .wdata(bus_wdata), .q(cell_q[k])
    );
  end

  // steered read: OR of the single live hit, zero when terminated
  logic [DATA_W-1:0] steer_val;
  always_comb begin
    steer_val = '0;
    for (int k = 0; k < N; k++)
      if (uni_hit[k] && copy_en[k]) steer_val |= cell_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_valid;
      if (sel_rd)      bus_rdata <= sel_word;
      else if (dat_rd) bus_rdata <= steer_val;
      else             bus_rdata <= '0;
    end
  end

  a_r9_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> bus_ready);
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !bus_ready);
  a_r5_unicast_single: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !bcast) |-> $onehot0(wr_mask));
  a_r8_term_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !live) |=> (bus_rdata == '0));
  a_r3_bcast_covers_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && bcast) |-> ((wr_mask & copy_en) == copy_en));

endmodule

// File: tb/tb_steer_bank.sv
`timescale 1ns/1ps
module tb_steer_bank;
  localparam int NG = 3, NC = 3, N = NG * NC;
  localparam logic [7:0] A_SEL = 8'h00, A_DAT = 8'h04;

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ready;
  logic [N-1:0] copy_en = '1;

  int checks = 0, failures = 0;
  logic [31:0] exp_q [N];

  always #5 clk = ~clk;

  steer_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .copy_en(copy_en)
  );

  function automatic logic [31:0] selw(input logic bc, input int g, input int c);
    return {bc, 27'd0, 2'(g), 2'(c)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
    rd = bus_rdata;
    chk("R9 ready", {31'd0, bus_ready}, 32'd1);
    @(negedge clk);
    chk("R9 idle", {31'd0, bus_ready}, 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    xfer(1'b1, a, d, dummy);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    xfer(1'b0, a, '0, v);
    chk(req, v, exp);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < N; k++) begin
      wr(A_SEL, selw(1'b0, k / NC, k % NC));
      rd_chk(req, A_DAT, exp_q[k]);
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 selector", A_SEL, 32'h8000_0000);
    rd_chk("R1 copy0", A_DAT, 32'h0);
    check_all("R1 all copies zero");
  endtask

  task automatic t_selector();
    wr(A_SEL, selw(1'b0, 2, 1));
    rd_chk("R2 fields", A_SEL, 32'h0000_0009);
    wr(A_SEL, 32'hFFFF_FFFF);
    rd_chk("R2 spare bits zero", A_SEL, 32'h8000_000F);
  endtask

  task automatic t_bcast();
    wr(A_SEL, selw(1'b1, 0, 0));
    wr(A_DAT, 32'hA5A5_0001);
    for (int k = 0; k < N; k++) exp_q[k] = 32'hA5A5_0001;
    check_all("R3 broadcast");
  endtask

  task automatic t_bcast_gated();
    wr(A_SEL, selw(1'b1, 0, 0));
    copy_en = '1; copy_en[2] = 0; copy_en[7] = 0;
    wr(A_DAT, 32'h1234_0000);
    for (int k = 0; k < N; k++) if (k != 2 && k != 7) exp_q[k] = 32'h1234_0000;
    copy_en = '1;
    check_all("R4 gated copies kept");
  endtask

  task automatic t_unicast();
    wr(A_SEL, selw(1'b0, 1, 2));
    wr(A_DAT, 32'hDEAD_0005);
    exp_q[5] = 32'hDEAD_0005;
    check_all("R5 unicast");
  endtask

  task automatic t_read_mode();
    wr(A_SEL, selw(1'b1, 1, 2));
    rd_chk("R7 read bcast set", A_DAT, 32'hDEAD_0005);
    wr(A_SEL, selw(1'b0, 1, 2));
    rd_chk("R7 read bcast clear", A_DAT, 32'hDEAD_0005);
    wr(A_SEL, selw(1'b1, 0, 2));
    rd_chk("R7 other copy", A_DAT, exp_q[2]);
  endtask

  task automatic t_terminated();
    copy_en = '1; copy_en[5] = 0;
    wr(A_SEL, selw(1'b0, 1, 2));
    rd_chk("R8 gated read", A_DAT, 32'h0);
    wr(A_SEL, selw(1'b1, 1, 2));
    rd_chk("R8 gated read bcast", A_DAT, 32'h0);
    wr(A_SEL, selw(1'b0, 1, 2));
    wr(A_DAT, 32'h0000_0BAD);
    copy_en = '1;
    rd_chk("R6 dropped write", A_DAT, 32'hDEAD_0005);
    check_all("R6 nothing else changed");
  endtask

  task automatic t_out_of_range();
    wr(A_SEL, selw(1'b0, 3, 0));
    rd_chk("R10 group out of range read", A_DAT, 32'h0);
    wr(A_DAT, 32'h7777_7777);
    wr(A_SEL, selw(1'b0, 0, 3));
    rd_chk("R10 copy out of range read", A_DAT, 32'h0);
    wr(A_DAT, 32'h6666_6666);
    check_all("R10 no copy written");
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) exp_q[k] = '0;
    repeat (3) @(negedge clk);
    chk("R9 ready in reset", {31'd0, bus_ready}, 32'd0);
    rst_n = 1;
    t_reset();
    t_selector();
    t_bcast();
    t_bcast_gated();
    t_unicast();
    t_read_mode();
    t_terminated();
    t_out_of_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule